// File: doc/BRIEF.md
# Cache Control Register and Flush Trigger

This block sits beside the on-chip cache of a processor and governs when that cache must be flushed and which addresses may be cached at all. Software programs one 8-bit configuration byte. It first writes a selector value to an index I/O port and then reads or writes the byte through a neighbouring data I/O port. Each selection is good for exactly one data access, so a read-modify-write needs two selections.

Two external events request a flush. The first is a request for the bus from another master (HOLD going active), which asks for a whole-cache flush when the corresponding configuration bit is set. The second is any change of the address-bit-20 mask input, which always asks for a flush limited to the lines that alias into the low 64 KiB of each 1 MiB block. A separate configuration bit marks that low 64 KiB window of every 1 MiB block as non-cacheable. A lookup address comes in, and a cacheable flag goes out in the same cycle. The cache array is not part of this block.

Top module: `cachectl_top`

## Requirements
- R1: After an index-port (address 0022h) write of C0h, the next data-port (address 0023h) write stores its byte into the configuration register, and after another C0h selection a data-port read returns that byte combinationally while io_rd is high.
- R2: After reset the configuration byte is 00h, flush_o and flush_full_o are 0, and cacheable_o is 1 for every lookup address.
- R3: A data-port access that does not directly follow an index-port write is ignored: a read returns FFh and a write leaves the register unchanged. Any data-port access or index-port read consumes the selection.
- R4: Index values other than C0h select nothing. Data writes after them are dropped, and data reads return FFh.
- R5: When configuration bit 5 is 1, a rising edge of bus_hold produces a one-cycle flush_o pulse with flush_full_o = 1. The pulse appears in the third clock edge after the input changes (two synchronizer stages plus one output register). With bit 5 at 0, or on a falling edge, no pulse appears.
- R6: When configuration bit 0 is 1, cacheable_o is 0 exactly for lookup addresses whose bits 19..16 are all zero. When bit 0 is 0, cacheable_o is 1 everywhere.
- R7: Every change of a20_mask, rising or falling, produces a one-cycle flush_o pulse with flush_full_o = 0, whatever the configuration, and with the same latency as R5.
- R8: A HOLD trigger and an A20 trigger in the same cycle merge into one pulse with flush_full_o = 1. flush_full_o is 0 whenever flush_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | IO_AW | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, FFh when nothing is selected |
| bus_hold | input | 1 | Bus request from another master, asynchronous |
| a20_mask | input | 1 | Address-bit-20 mask, asynchronous |
| lk_addr | input | PA_W | Physical address of a cache lookup |
| flush_o | output | 1 | One-cycle flush request |
| flush_full_o | output | 1 | 1 = whole cache, 0 = A20-aliased lines only |
| cacheable_o | output | 1 | Lookup address may be cached |

## Verification
The bench uses the default build: a 24-bit physical address, 1 MiB blocks with a 64 KiB low window, and two synchronizer stages. With these values every one of the 256 selector values and every one of the 256 data bytes can be swept. Every 64 KiB step of the whole 16 MiB space can be looked up under both settings of the window bit. The short synchronizer makes the fixed three-edge flush latency easy to sample at the exact cycle, which also lets the bench check that each pulse ends one cycle later.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;

   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   localparam byte_t IDLE_READ = 8'hFF;

   typedef enum logic {
      SCOPE_ALIAS = 1'b0,
      SCOPE_ALL   = 1'b1
   } flush_scope_e;

endpackage

// File: rtl/cachectl_portif.sv
module cachectl_portif
   import cachectl_pkg::*;
#(
   parameter int          IO_AW    = 16,
   parameter logic [15:0] IDX_PORT = 16'h0022,
   parameter logic [15:0] DAT_PORT = 16'h0023,
   parameter byte_t       SEL_IDX  = 8'hC0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [IO_AW-1:0] io_addr,
   input  byte_t            io_wdata,
   output byte_t            io_rdata,
   output byte_t            cfg_q
);

   localparam logic [IO_AW-1:0] IDX_A = IO_AW'(IDX_PORT);
   localparam logic [IO_AW-1:0] DAT_A = IO_AW'(DAT_PORT);

   byte_t idx_q;
   logic  armed_q;
   logic  hit_idx, hit_dat, sel_ok;

   assign hit_idx = (io_addr == IDX_A);
   assign hit_dat = (io_addr == DAT_A);
   assign sel_ok  = armed_q && (idx_q == SEL_IDX);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q   <= '0;
         armed_q <= 1'b0;
         cfg_q   <= '0;
      end else if (io_wr && hit_idx) begin
         idx_q   <= io_wdata;
         armed_q <= 1'b1;
      end else if ((io_wr || io_rd) && hit_dat) begin
         armed_q <= 1'b0;
         if (io_wr && sel_ok)
            cfg_q <= io_wdata;
      end else if (io_rd && hit_idx) begin
         armed_q <= 1'b0;
      end
   end

   always_comb begin
      io_rdata = IDLE_READ;
      if (io_rd && !io_wr && hit_dat && sel_ok)
         io_rdata = cfg_q;
   end

endmodule

// File: rtl/cachectl_flush.sv
module cachectl_flush
   import cachectl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic hold_en,
   input  logic bus_hold,
   input  logic a20_mask,
   output logic flush_o,
   output logic flush_full_o
);

   logic [1:0] chain_q [SYNC_STAGES];
   logic [1:0] synced;
   logic [1:0] prev_q;
   logic       hold_rise, a20_flip;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[gi] <= '0;
               else     chain_q[gi] <= {bus_hold, a20_mask};
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[gi] <= '0;
               else     chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign synced    = chain_q[SYNC_STAGES-1];
   assign hold_rise = hold_en && synced[1] && !prev_q[1];
   assign a20_flip  = synced[0] ^ prev_q[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q       <= '0;
         flush_o      <= 1'b0;
         flush_full_o <= SCOPE_ALIAS;
      end else begin
         prev_q       <= synced;
         flush_o      <= hold_rise || a20_flip;
         flush_full_o <= hold_rise ? SCOPE_ALL : SCOPE_ALIAS;
      end
   end

endmodule

// File: rtl/cachectl_window.sv
module cachectl_window #(
   parameter int PA_W        = 24,
   parameter int BLOCK_LOG2  = 20,
   parameter int WINDOW_LOG2 = 16
) (
   input  logic            uncache_low,
   input  logic [PA_W-1:0] lk_addr,
   output logic            cacheable_o
);

   localparam int SPAN = BLOCK_LOG2 - WINDOW_LOG2;

   logic [SPAN-1:0] slot;
   assign slot        = lk_addr[BLOCK_LOG2-1:WINDOW_LOG2];
   assign cacheable_o = !(uncache_low && (slot == '0));

endmodule

// File: rtl/cachectl_top.sv
module cachectl_top
   import cachectl_pkg::*;
#(
   parameter int          IO_AW       = 16,
   parameter logic [15:0] IDX_PORT    = 16'h0022,
   parameter logic [15:0] DAT_PORT    = 16'h0023,
   parameter logic [7:0]  SEL_IDX     = 8'hC0,
   parameter int          HOLD_EN_BIT = 5,
   parameter int          LOWUNC_BIT  = 0,
   parameter int          SYNC_STAGES = 2,
   parameter int          PA_W        = 24,
   parameter int          BLOCK_LOG2  = 20,
   parameter int          WINDOW_LOG2 = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [7:0]       io_wdata,
   output logic [7:0]       io_rdata,
   input  logic             bus_hold,
   input  logic             a20_mask,
   input  logic [PA_W-1:0]  lk_addr,
   output logic             flush_o,
   output logic             flush_full_o,
   output logic             cacheable_o
);

   generate
      if (WINDOW_LOG2 < 1 || WINDOW_LOG2 >= BLOCK_LOG2 || BLOCK_LOG2 > PA_W) begin : g_bad_map
         $error("cachectl_top: window must be smaller than block, block within address");
      end
      if (HOLD_EN_BIT < 0 || HOLD_EN_BIT >= BYTE_W || LOWUNC_BIT < 0 ||
          LOWUNC_BIT >= BYTE_W || HOLD_EN_BIT == LOWUNC_BIT) begin : g_bad_bits
         $error("cachectl_top: control bit positions invalid");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("cachectl_top: at least one synchronizer stage needed");
      end
      if (IO_AW < 2 || IO_AW > 16) begin : g_bad_io
         $error("cachectl_top: IO_AW out of range");
      end
   endgenerate

   byte_t cfg_q;

   cachectl_portif #(
      .IO_AW(IO_AW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .SEL_IDX(SEL_IDX)
   ) u_port (
      .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_q(cfg_q)
   );

   cachectl_flush #(.SYNC_STAGES(SYNC_STAGES)) u_flush (
      .clk(clk), .rst(rst), .hold_en(cfg_q[HOLD_EN_BIT]), .bus_hold(bus_hold),
      .a20_mask(a20_mask), .flush_o(flush_o), .flush_full_o(flush_full_o)
   );

   cachectl_window #(
      .PA_W(PA_W), .BLOCK_LOG2(BLOCK_LOG2), .WINDOW_LOG2(WINDOW_LOG2)
   ) u_win (
      .uncache_low(cfg_q[LOWUNC_BIT]), .lk_addr(lk_addr), .cacheable_o(cacheable_o)
   );

endmodule

// File: rtl/cachectl_chk.sv
module cachectl_chk #(
   parameter int          IO_AW       = 16,
   parameter logic [15:0] DAT_PORT    = 16'h0023,
   parameter int          HOLD_EN_BIT = 5,
   parameter int          LOWUNC_BIT  = 0,
   parameter int          PA_W        = 24,
   parameter int          BLOCK_LOG2  = 20,
   parameter int          WINDOW_LOG2 = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             io_wr,
   input logic             io_rd,
   input logic [IO_AW-1:0] io_addr,
   input logic [7:0]       io_rdata,
   input logic [7:0]       cfg_q,
   input logic [PA_W-1:0]  lk_addr,
   input logic             flush_o,
   input logic             flush_full_o,
   input logic             cacheable_o
);

   p_idle_read_r3: assert property (@(posedge clk) disable iff (rst)
      !(io_rd && io_addr == IO_AW'(DAT_PORT)) |-> io_rdata == 8'hFF);

   p_cfg_only_by_write_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(io_wr) |-> $stable(cfg_q));

   p_full_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
      (flush_o && flush_full_o) |-> $past(cfg_q[HOLD_EN_BIT]));

   p_scope_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !flush_o |-> !flush_full_o);

   p_uncache_window_r6: assert property (@(posedge clk) disable iff (rst)
      !cacheable_o |-> (cfg_q[LOWUNC_BIT] && lk_addr[BLOCK_LOG2-1:WINDOW_LOG2] == '0));

endmodule

bind cachectl_top cachectl_chk #(
   .IO_AW(IO_AW), .DAT_PORT(DAT_PORT), .HOLD_EN_BIT(HOLD_EN_BIT),
   .LOWUNC_BIT(LOWUNC_BIT), .PA_W(PA_W), .BLOCK_LOG2(BLOCK_LOG2),
   .WINDOW_LOG2(WINDOW_LOG2)
) u_chk (
   .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
   .io_rdata(io_rdata), .cfg_q(cfg_q), .lk_addr(lk_addr), .flush_o(flush_o),
   .flush_full_o(flush_full_o), .cacheable_o(cacheable_o)
);

// File: tb/sim_cachectl_top.sv
`timescale 1ns/1ps
module sim_cachectl_top;

   localparam logic [15:0] IDXP = 16'h0022;
   localparam logic [15:0] DATP = 16'h0023;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        bus_hold = 1'b0, a20_mask = 1'b0;
   logic [23:0] lk_addr = '0;
   logic        flush_o, flush_full_o, cacheable_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cachectl_top u0 (
      .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .bus_hold(bus_hold),
      .a20_mask(a20_mask), .lk_addr(lk_addr), .flush_o(flush_o),
      .flush_full_o(flush_full_o), .cacheable_o(cacheable_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_rd = 1'b1; io_addr = a;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic set_cfg(input logic [7:0] v);
      io_write(IDXP, 8'hC0);
      io_write(DATP, v);
   endtask

   task automatic get_cfg(output logic [7:0] v);
      io_write(IDXP, 8'hC0);
      io_read(DATP, v);
   endtask

   // drive new levels, then sample on the third edge and one edge later
   task automatic trig(input logic h, input logic a, input int ef, input int efull,
                       input string tag);
      @(negedge clk);
      bus_hold = h; a20_mask = a;
      repeat (3) @(posedge clk);
      #1;
      chk({tag, " pulse"}, flush_o, ef);
      chk({tag, " scope"}, flush_full_o, efull);
      @(posedge clk);
      #1;
      chk({tag, " pulse ends"}, flush_o, 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (4) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R2: reset state
      #1;
      chk("R2 flush", flush_o, 0);
      chk("R2 scope", flush_full_o, 0);
      lk_addr = 24'h000000; #1 chk("R2 cacheable", cacheable_o, 1);
      get_cfg(r);
      chk("R2 cfg", r, 8'h00);

      // R1: every data byte stored and read back
      for (int v = 0; v < 256; v++) begin
         set_cfg(8'(v));
         get_cfg(r);
         chk("R1 readback", r, v);
      end

      // R3: selection consumed by one access
      set_cfg(8'h3C);
      io_read(DATP, r);
      chk("R3 unarmed read", r, 8'hFF);
      io_write(DATP, 8'h11);
      get_cfg(r);
      chk("R3 unarmed write dropped", r, 8'h3C);
      io_write(IDXP, 8'hC0);
      io_read(DATP, r);
      chk("R3 first read", r, 8'h3C);
      io_read(DATP, r);
      chk("R3 second read", r, 8'hFF);
      io_write(IDXP, 8'hC0);
      io_read(IDXP, r);
      chk("R3 index read value", r, 8'hFF);
      io_write(DATP, 8'h77);
      get_cfg(r);
      chk("R3 index read consumes", r, 8'h3C);
      io_write(IDXP, 8'hC0);
      io_write(DATP, 8'h5A);
      io_write(DATP, 8'hA5);
      get_cfg(r);
      chk("R3 second write dropped", r, 8'h5A);

      // R4: every other selector value inert
      for (int i = 0; i < 256; i++) begin
         if (i != 'hC0) begin
            io_write(IDXP, 8'(i));
            io_write(DATP, 8'hE7);
            io_write(IDXP, 8'(i));
            io_read(DATP, r);
            chk("R4 foreign read", r, 8'hFF);
         end
      end
      get_cfg(r);
      chk("R4 cfg untouched", r, 8'h5A);

      // R6: sweep every 64 KiB step under both window settings
      for (int m = 0; m < 2; m++) begin
         set_cfg(m == 1 ? 8'h01 : 8'h00);
         for (int s = 0; s < 256; s++) begin
            @(negedge clk);
            lk_addr = {8'(s), 16'(s * 97 + 13)};
            #1;
            chk("R6 cacheable", cacheable_o,
                (m == 1 && (s % 16) == 0) ? 0 : 1);
         end
      end

      // R5: hold edges
      set_cfg(8'h00);
      trig(1'b1, 1'b0, 0, 0, "R5 disabled rise");
      trig(1'b0, 1'b0, 0, 0, "R5 fall");
      set_cfg(8'h20);
      trig(1'b1, 1'b0, 1, 1, "R5 enabled rise");
      trig(1'b1, 1'b0, 0, 0, "R5 held high");
      trig(1'b0, 1'b0, 0, 0, "R5 enabled fall");

      // R7: a20 changes, with and without the hold enable
      trig(1'b0, 1'b1, 1, 0, "R7 rise");
      trig(1'b0, 1'b0, 1, 0, "R7 fall");
      set_cfg(8'h00);
      trig(1'b0, 1'b1, 1, 0, "R7 rise no enable");
      trig(1'b1, 1'b0, 1, 0, "R7 fall with disabled hold");
      trig(1'b0, 1'b0, 0, 0, "R7 quiet");

      // R8: coincident triggers merge
      set_cfg(8'h20);
      trig(1'b1, 1'b1, 1, 1, "R8 merge");
      trig(1'b0, 1'b1, 0, 0, "R8 quiet");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule